// File: doc/BRIEF.md
# Hardware Trigger and Burst Qualifier for a DMA Channel

This block sits in front of one DMA channel engine. It turns a request line from a peripheral, or a software trigger pulse, into a stream of per-beat go requests. The engine answers each request with a completion strobe. A small set of configuration inputs selects the behaviour:

- whether hardware requests are honoured at all;
- whether the request is edge or level sensitive, and which polarity is active;
- whether each trigger yields one transfer or a burst of 2^n transfers.

When a burst finishes, the block tells the source and destination address generators, each on its own enable, to rewind to the burst start address. A trigger that arrives while a burst is running is held as a single pending trigger. A descriptor-end strobe, combined with the clear-trigger setting, parks the channel until software triggers it again.

The request input crosses into the clock domain through a synchronizer of `SYNC_STAGES` flops before the block detects edges or levels. A burst counter is loaded on every accepted trigger and counts down on each acknowledged beat. The counter supplies the burst-boundary marker.

Top module: `trig_burst_ctrl`

## Requirements
- R1: After reset, `trig_active`, `beat_go`, `burst_last`, `src_rewind` and `dst_rewind` are all 0.
- R2: With `cfg_hw_en` = 0, activity on `req_in` starts no transfer. A one-cycle `sw_trig` pulse starts a burst, and `beat_go` is high in the cycle after the pulse.
- R3: Edge mode (`cfg_level` = 0). With `cfg_pol` = 1 a rising edge of `req_in` is a trigger, and with `cfg_pol` = 0 a falling edge is. The opposite edge does nothing. When `req_in` changes just before clock edge k, `beat_go` rises after clock edge k+2.
- R4: With `cfg_burst_en` = 0, each trigger event yields exactly one acknowledged beat. `burst_last` is high on that beat.
- R5: With `cfg_burst_en` = 1, each trigger yields 2^`cfg_burst_pow` beats. Field values above 10 act as 10, so the largest burst is 1024 beats.
- R6: Level mode with burst (`cfg_level` = 1, `cfg_burst_en` = 1). Beats continue for as long as the request stays at its active level (`cfg_pol` = 1 means high, 0 means low). Each burst reload costs one idle cycle, so a burst of 4 gives 16 acknowledged beats in every 20 cycles. Once the level goes inactive, `beat_go` stays 0.
- R7: Level mode without burst. Each evaluation of the active level yields one beat, so a held active level gives one beat every second cycle. An inactive level gives none.
- R8: A trigger (software pulse or qualifying edge) that arrives while a burst is busy is latched as one pending trigger, and further ones are dropped. This also holds in the cycle of the burst's last acknowledged beat. The pending trigger starts the next burst one idle cycle after the current burst ends.
- R9: `burst_last` is high exactly on the final beat of each burst.
- R10: `src_rewind` and `dst_rewind` pulse together with the acknowledged final beat of a burst. Each pulses only when its own enable (`cfg_src_wrap`, `cfg_dst_wrap`) is set and `cfg_burst_en` = 1. The two enables are independent.
- R11: When `desc_end` is high and `cfg_clr_trig` = 1, in the next cycle `trig_active` = 0, the remaining beats are dropped and any pending trigger is dropped. Hardware requests are then ignored until the next `sw_trig`. This clear takes priority over a software trigger in the same cycle.
- R12: The burst counter advances only on cycles where `beat_go` and `xfer_done` are both high. Without `xfer_done`, `beat_go` stays high and no beat is counted.
- R13: When `desc_end` is high and `cfg_clr_trig` = 0, `trig_active` stays 1 and hardware requests keep starting bursts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hw_en | input | 1 | Honour hardware requests |
| cfg_level | input | 1 | 1 = level sensitive, 0 = edge sensitive |
| cfg_pol | input | 1 | 1 = high / rising active, 0 = low / falling active |
| cfg_burst_en | input | 1 | Enable bursts of 2^n beats |
| cfg_burst_pow | input | POW_W | Burst size exponent, clamped to MAX_POW |
| cfg_src_wrap | input | 1 | Rewind source address at each burst end |
| cfg_dst_wrap | input | 1 | Rewind destination address at each burst end |
| cfg_clr_trig | input | 1 | Drop the trigger state when a descriptor ends |
| req_in | input | 1 | Asynchronous hardware request |
| sw_trig | input | 1 | Software trigger pulse |
| xfer_done | input | 1 | Engine acknowledges the current beat |
| desc_end | input | 1 | Engine finished the current descriptor |
| trig_active | output | 1 | Channel is in the triggered state |
| beat_go | output | 1 | Request one beat from the engine |
| burst_last | output | 1 | Current beat is the last of its burst |
| src_rewind | output | 1 | Source side returns to its burst start |
| dst_rewind | output | 1 | Destination side returns to its burst start |

## Verification
Two collisions can fall into the same cycle. The first is a new trigger arriving in the exact cycle the last beat of a burst is acknowledged. The bench provokes it by counting beats from a known software pulse and raising `sw_trig` on the fourth beat. It checks that `burst_last` is high in that cycle and that exactly two full bursts of beats follow. The second is a software trigger in the same cycle as a clearing descriptor end. The bench judges it by the absence of any later beat and by a hardware edge that must also stay ignored.

// File: rtl/trig_burst_ctrl.sv
module trig_burst_ctrl #(
  parameter int MAX_POW     = 10,
  parameter int POW_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_hw_en,
  input  logic             cfg_level,
  input  logic             cfg_pol,
  input  logic             cfg_burst_en,
  input  logic [POW_W-1:0] cfg_burst_pow,
  input  logic             cfg_src_wrap,
  input  logic             cfg_dst_wrap,
  input  logic             cfg_clr_trig,
  input  logic             req_in,
  input  logic             sw_trig,
  input  logic             xfer_done,
  input  logic             desc_end,
  output logic             trig_active,
  output logic             beat_go,
  output logic             burst_last,
  output logic             src_rewind,
  output logic             dst_rewind
);

  localparam int CNT_W = MAX_POW + 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   req_d;
  logic [CNT_W-1:0]       cnt_q;
  logic                   pend_q;
  logic                   hold_q;
  logic                   trig_q;

  logic             req_s, level_act, edge_hit, hw_ok, clr_now;
  logic             idle, lvl_burst, tev, lev_ev, load, ack, fin;
  logic [POW_W-1:0] pow_eff;
  logic [CNT_W-1:0] burst_len;

  assign req_s     = sync_q[SYNC_STAGES-1];
  assign level_act = cfg_pol ? req_s : ~req_s;
  assign edge_hit  = cfg_pol ? (req_s & ~req_d) : (~req_s & req_d);
  assign hw_ok     = cfg_hw_en & ~hold_q;
  assign clr_now   = desc_end & cfg_clr_trig;

  assign pow_eff   = (cfg_burst_pow > POW_W'(MAX_POW)) ? POW_W'(MAX_POW) : cfg_burst_pow;
  assign burst_len = cfg_burst_en ? (CNT_W'(1) << pow_eff) : CNT_W'(1);

  assign idle      = (cnt_q == '0);
  assign lvl_burst = cfg_hw_en & cfg_level & cfg_burst_en;
  assign tev       = sw_trig | (hw_ok & ~cfg_level & edge_hit);
  assign lev_ev    = hw_ok & cfg_level & level_act;
  assign load      = idle & (tev | pend_q | lev_ev);

  assign beat_go     = ~idle & (~lvl_burst | level_act);
  assign burst_last  = beat_go & (cnt_q == CNT_W'(1));
  assign ack         = beat_go & xfer_done;
  assign fin         = ack & burst_last & cfg_burst_en;
  assign src_rewind  = fin & cfg_src_wrap;
  assign dst_rewind  = fin & cfg_dst_wrap;
  assign trig_active = trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      req_d  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], req_in};
      req_d  <= req_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      hold_q <= 1'b0;
      trig_q <= 1'b0;
    end else if (clr_now) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      hold_q <= 1'b1;
      trig_q <= 1'b0;
    end else begin
      if (sw_trig) hold_q <= 1'b0;
      if (load) begin
        cnt_q  <= burst_len;
        pend_q <= 1'b0;
        trig_q <= 1'b1;
      end else begin
        if (ack)          cnt_q  <= cnt_q - CNT_W'(1);
        if (!idle && tev) pend_q <= 1'b1;
      end
    end
  end

  // R8: a pending trigger on an idle channel starts a burst in the next cycle
  a_r8_pend_served: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && idle && !clr_now) |=> !idle);

  // R11: a clearing descriptor end leaves nothing running
  a_r11_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clr_now |=> (!trig_active && !beat_go && !pend_q));

  // R2: software-only mode never starts a burst without a pulse
  a_r2_sw_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_hw_en && !sw_trig && !pend_q && idle) |=> idle);

  // R9: the acknowledged final beat empties the counter
  a_r9_last_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_last && xfer_done) |=> idle);

  // R10: rewinds are only issued for an acknowledged boundary beat
  a_r10_rewind_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (src_rewind || dst_rewind) |-> (burst_last && xfer_done && cfg_burst_en));

endmodule

// File: tb/trig_burst_ctrl_tb.sv
`timescale 1ns/1ps
module trig_burst_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic cfg_hw_en, cfg_level, cfg_pol, cfg_burst_en;
  logic [3:0] cfg_burst_pow;
  logic cfg_src_wrap, cfg_dst_wrap, cfg_clr_trig;
  logic req_in, sw_trig, xfer_done, desc_end;
  logic trig_active, beat_go, burst_last, src_rewind, dst_rewind;

  int checks = 0, errors = 0;
  int acks = 0, lasts = 0, srw = 0, drw = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  trig_burst_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_hw_en(cfg_hw_en), .cfg_level(cfg_level), .cfg_pol(cfg_pol),
    .cfg_burst_en(cfg_burst_en), .cfg_burst_pow(cfg_burst_pow),
    .cfg_src_wrap(cfg_src_wrap), .cfg_dst_wrap(cfg_dst_wrap), .cfg_clr_trig(cfg_clr_trig),
    .req_in(req_in), .sw_trig(sw_trig), .xfer_done(xfer_done), .desc_end(desc_end),
    .trig_active(trig_active), .beat_go(beat_go), .burst_last(burst_last),
    .src_rewind(src_rewind), .dst_rewind(dst_rewind)
  );

  always @(negedge clk) begin
    #1;
    if (beat_go && xfer_done) acks++;
    if (burst_last && xfer_done) lasts++;
    if (src_rewind) srw++;
    if (dst_rewind) drw++;
  end

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic clr_cnt();
    acks = 0; lasts = 0; srw = 0; drw = 0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cfg_hw_en = 0; cfg_level = 0; cfg_pol = 1; cfg_burst_en = 0; cfg_burst_pow = 0;
    cfg_src_wrap = 0; cfg_dst_wrap = 0; cfg_clr_trig = 0;
    req_in = 0; sw_trig = 0; xfer_done = 1; desc_end = 0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    clr_cnt();
  endtask

  task automatic pulse_sw();
    sw_trig = 1'b1; @(negedge clk); sw_trig = 1'b0;
  endtask

  task automatic window(input int n);
    @(negedge clk); clr_cnt();
    repeat (n - 1) @(negedge clk);
    #2;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R1 trig_active", int'(trig_active), 0);
    chk("R1 beat_go", int'(beat_go), 0);
    chk("R1 burst_last/rewinds", int'(burst_last | src_rewind | dst_rewind), 0);
  endtask

  task automatic t_sw_only();
    do_reset();
    cfg_burst_en = 1; cfg_burst_pow = 2;
    for (int i = 0; i < 4; i++) begin req_in = ~req_in; wait_n(4); end
    chk("R2 request ignored", acks, 0);
    clr_cnt();
    sw_trig = 1'b1; @(negedge clk); sw_trig = 1'b0; #1;
    chk("R2 go after pulse", int'(beat_go), 1);
    wait_n(10);
    chk("R2 sw burst beats", acks, 4);
    chk("R2 trig_active", int'(trig_active), 1);
  endtask

  task automatic t_rise_edge();
    do_reset();
    cfg_hw_en = 1; cfg_pol = 1; cfg_burst_en = 1; cfg_burst_pow = 3;
    req_in = 1'b1;
    @(negedge clk); #1; chk("R3 latency k", int'(beat_go), 0);
    @(negedge clk); #1; chk("R3 latency k+1", int'(beat_go), 0);
    @(negedge clk); #1; chk("R3 latency k+2", int'(beat_go), 1);
    wait_n(12);
    chk("R5 burst of 8", acks, 8);
    chk("R9 one boundary", lasts, 1);
    clr_cnt(); req_in = 1'b0; wait_n(12);
    chk("R3 opposite edge ignored", acks, 0);
  endtask

  task automatic t_fall_single();
    do_reset();
    req_in = 1'b1; wait_n(5);
    cfg_hw_en = 1; cfg_pol = 0; cfg_src_wrap = 1; cfg_dst_wrap = 1;
    wait_n(5); clr_cnt();
    req_in = 1'b0; wait_n(8);
    chk("R3 falling edge", acks, 1);
    chk("R4 single last", lasts, 1);
    chk("R10 no rewind without burst", srw + drw, 0);
    clr_cnt(); req_in = 1'b1; wait_n(8);
    chk("R3 rising ignored with pol 0", acks, 0);
  endtask

  task automatic t_pow();
    do_reset();
    cfg_burst_en = 1; cfg_burst_pow = 15;
    pulse_sw(); wait_n(1100);
    chk("R5 clamp 1024", acks, 1024);
    chk("R9 clamp one last", lasts, 1);
    clr_cnt(); cfg_burst_pow = 0;
    pulse_sw(); wait_n(6);
    chk("R5 pow 0", acks, 1);
  endtask

  task automatic t_level_burst();
    do_reset();
    cfg_hw_en = 1; cfg_level = 1; cfg_pol = 1; cfg_burst_en = 1; cfg_burst_pow = 2;
    req_in = 1'b1; wait_n(6);
    window(20);
    chk("R6 level beats", acks, 16);
    chk("R9 level boundaries", lasts, 4);
    req_in = 1'b0; wait_n(4);
    window(10);
    chk("R6 inactive level", acks, 0);
  endtask

  task automatic t_level_single();
    do_reset();
    req_in = 1'b1; wait_n(5);
    cfg_hw_en = 1; cfg_level = 1; cfg_pol = 0;
    window(10);
    chk("R7 inactive high", acks, 0);
    req_in = 1'b0; wait_n(5);
    window(20);
    chk("R7 alternate beats", acks, 10);
  endtask

  task automatic t_pending();
    do_reset();
    cfg_burst_en = 1; cfg_burst_pow = 2;
    pulse_sw();
    sw_trig = 1'b1; wait_n(2); sw_trig = 1'b0;
    wait_n(20);
    chk("R8 one pending only", acks, 8);
    chk("R8 two boundaries", lasts, 2);
  endtask

  task automatic t_collide();
    do_reset();
    cfg_burst_en = 1; cfg_burst_pow = 2;
    pulse_sw();
    wait_n(3);
    sw_trig = 1'b1; #1;
    chk("R9 last beat marker", int'(burst_last), 1);
    @(negedge clk); sw_trig = 1'b0; #1;
    chk("R8 idle gap", int'(beat_go), 0);
    wait_n(12);
    chk("R8 trigger on last beat", acks, 8);
  endtask

  task automatic t_ack();
    do_reset();
    cfg_burst_en = 1; cfg_burst_pow = 1; xfer_done = 1'b0;
    pulse_sw(); wait_n(5); #1;
    chk("R12 go held", int'(beat_go), 1);
    chk("R12 no count", acks, 0);
    xfer_done = 1'b1; wait_n(5);
    chk("R12 resumes", acks, 2);
  endtask

  task automatic t_wrap();
    do_reset();
    cfg_burst_en = 1; cfg_burst_pow = 1; cfg_src_wrap = 1;
    pulse_sw(); wait_n(6);
    chk("R10 src rewind", srw, 1);
    chk("R10 dst quiet", drw, 0);
    clr_cnt(); cfg_src_wrap = 0; cfg_dst_wrap = 1;
    pulse_sw(); wait_n(6);
    chk("R10 dst rewind", drw, 1);
    chk("R10 src quiet", srw, 0);
  endtask

  task automatic t_clear();
    do_reset();
    cfg_hw_en = 1; cfg_burst_en = 1; cfg_burst_pow = 2; cfg_clr_trig = 1;
    pulse_sw(); wait_n(8);
    chk("R11 trig before clear", int'(trig_active), 1);
    desc_end = 1'b1; @(negedge clk); desc_end = 1'b0; #1;
    chk("R11 trig dropped", int'(trig_active), 0);
    clr_cnt(); req_in = 1'b1; wait_n(10);
    chk("R11 hw held off", acks, 0);
    pulse_sw(); wait_n(8);
    chk("R11 sw rearms", acks, 4);
    clr_cnt(); req_in = 1'b0; wait_n(4); req_in = 1'b1; wait_n(10);
    chk("R11 hw after rearm", acks, 4);
    desc_end = 1'b1; sw_trig = 1'b1; @(negedge clk); desc_end = 1'b0; sw_trig = 1'b0;
    clr_cnt(); wait_n(8);
    chk("R11 clear beats sw", acks, 0);
    req_in = 1'b0; wait_n(4); req_in = 1'b1; wait_n(10);
    chk("R11 still held", acks + int'(trig_active), 0);
  endtask

  task automatic t_no_clear();
    do_reset();
    cfg_hw_en = 1; cfg_burst_en = 1; cfg_burst_pow = 1;
    req_in = 1'b1; wait_n(8);
    desc_end = 1'b1; @(negedge clk); desc_end = 1'b0; #1;
    chk("R13 trig kept", int'(trig_active), 1);
    clr_cnt(); req_in = 1'b0; wait_n(4); req_in = 1'b1; wait_n(10);
    chk("R13 hw continues", acks, 2);
  endtask

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_sw_only();
    t_rise_edge();
    t_fall_single();
    t_pow();
    t_level_burst();
    t_level_single();
    t_pending();
    t_collide();
    t_ack();
    t_wrap();
    t_clear();
    t_no_clear();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule